// File: doc/BRIEF.md
# Multiplier-free transposed FIR filter

This block is a fixed-coefficient FIR filter for use where hard multipliers are unavailable or too costly. Every accepted input sample goes to all taps in the same cycle. Each coefficient is a compile-time constant, so its product is built only from shifts and additions or subtractions. At elaboration each coefficient is recoded into canonical signed digits, which keeps the number of nonzero digits, and so the number of adders, low.

The shifted copies of the sample, and their negations, sit in one shared pool. Each one is produced once and used by every tap whose recoded coefficient has a digit in that position, with or without coefficient symmetry. The tap products feed a chain of adders in transposed form, with a register after each adder. The head of the chain is the filter output, at full precision.

A sample is accepted on a clock edge where the valid input is high. The filter state moves only on those edges. A synchronous reset clears the state.

Top module: `fir_csd_transposed`

## Requirements
- R1: On a clock edge with `rst` high, all pipeline registers clear to zero. `out_data` then reads 0, and the first sample accepted after reset sees a zero history, so the output is `c0*x`.
- R2: One cycle after an edge where `in_valid` is high, `out_data` equals the sum over k of `c[k]*x[n-k]`. Here x[n] is the sample just accepted, x[n-k] is the sample accepted k valid edges earlier, and c[k] is bits [k*CW +: CW] of `COEF_VEC`, read as a signed value.
- R3: On an edge where `in_valid` is low, the sample input is ignored. `out_data` and the stored history hold, so the next valid sample continues the convolution as if the idle cycles were not there.
- R4: A unit impulse followed by zero samples produces c[0], c[1], ..., c[NTAPS-1] on successive valid cycles, then zero.
- R5: Samples and coefficients are two's complement, and negative values of either give exact signed results.
- R6: `out_data` is XW+CW+ceil(log2(NTAPS)) bits wide and never wraps. Its magnitude stays within 2^(XW-1) times the sum of the coefficient magnitudes, including for runs of the most negative sample.
- R7: Each tap's shift-and-add product equals the exact product of the current sample and that tap's coefficient.
- R8: A constant input of value A held for at least NTAPS valid samples gives a steady output of A times the sum of all coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_sample` is to be accepted on this edge |
| in_sample | input | XW | Signed input sample |
| out_data | output | XW+CW+ceil(log2(NTAPS)) | Signed full-precision filter output |

## Verification
Every filter result is due exactly one clock edge after the valid edge that accepted its newest sample. Between valid edges the output must not move. The bench drives inputs on the falling edge and compares the output on the next falling edge, which follows the single register stage. The reference is a behavioural sliding-window convolution that shifts only when valid was high and is cleared by reset. The comparison runs on every cycle: impulses with idle gaps, negative full-scale impulses, a step, alternating extreme values, random data with random valid, and a reset in mid-stream.

// File: rtl/fir_csd_pkg.sv
package fir_csd_pkg;

  // Signed digit (-1, 0, +1) at position pos of the canonical signed digit
  // form of value. An odd remainder takes the digit that leaves a multiple
  // of four, so no two nonzero digits are adjacent.
  function automatic int csd_digit(longint value, int pos);
    longint c;
    int d;
    c = value;
    d = 0;
    for (int i = 0; i <= pos; i++) begin
      if (c[0]) begin
        d = c[1] ? -1 : 1;
        c = c - longint'(d);
      end else begin
        d = 0;
      end
      c = c >>> 1;
    end
    return d;
  endfunction

  // Ceiling of log2, with a floor of one bit.
  function automatic int clog2_min1(int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return (r < 1) ? 1 : r;
  endfunction

endpackage

// File: rtl/fir_term_pool.sv
module fir_term_pool #(
  parameter int XW = 8,
  parameter int PW = 23,
  parameter int NDIG = 13,
  parameter logic [NDIG-1:0] USE_POS = '1,
  parameter logic [NDIG-1:0] USE_NEG = '1
) (
  input  logic signed [XW-1:0] x,
  output logic signed [PW-1:0] pos_terms [NDIG],
  output logic signed [PW-1:0] neg_terms [NDIG]
);

  logic signed [PW-1:0] x_ext;
  assign x_ext = {{(PW-XW){x[XW-1]}}, x};

  // Each shifted multiple, and its negation, is built once for all taps.
  for (genvar k = 0; k < NDIG; k++) begin : g_term
    if (USE_POS[k]) begin : g_pos
      assign pos_terms[k] = x_ext <<< k;
    end else begin : g_pos_off
      assign pos_terms[k] = '0;
    end
    if (USE_NEG[k]) begin : g_neg
      assign neg_terms[k] = -(x_ext <<< k);
    end else begin : g_neg_off
      assign neg_terms[k] = '0;
    end
  end

endmodule

// File: rtl/fir_const_mult.sv
module fir_const_mult
  import fir_csd_pkg::*;
#(
  parameter int PW = 23,
  parameter int NDIG = 13,
  parameter longint TAP_COEF = 0
) (
  input  logic signed [PW-1:0] pos_terms [NDIG],
  input  logic signed [PW-1:0] neg_terms [NDIG],
  output logic signed [PW-1:0] prod
);

  // Add the pool term that each nonzero signed digit selects.
  always_comb begin
    prod = '0;
    for (int k = 0; k < NDIG; k++) begin
      if (csd_digit(TAP_COEF, k) == 1)
        prod = prod + pos_terms[k];
      else if (csd_digit(TAP_COEF, k) == -1)
        prod = prod + neg_terms[k];
    end
  end

endmodule

// File: rtl/fir_sum_chain.sv
module fir_sum_chain #(
  parameter int NTAPS = 5,
  parameter int PW = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [PW-1:0] prods [NTAPS],
  output logic signed [PW-1:0] head
);

  logic signed [PW-1:0] stage_q [NTAPS];

  for (genvar i = 0; i < NTAPS; i++) begin : g_stage
    if (i == NTAPS - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)      stage_q[i] <= '0;
        else if (en)  stage_q[i] <= prods[i];
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)      stage_q[i] <= '0;
        else if (en)  stage_q[i] <= prods[i] + stage_q[i+1];
      end
    end
  end

  assign head = stage_q[0];

endmodule

// File: rtl/fir_csd_transposed.sv
module fir_csd_transposed
  import fir_csd_pkg::*;
#(
  parameter int NTAPS = 5,
  parameter int XW = 8,
  parameter int CW = 12,
  parameter logic [NTAPS*CW-1:0] COEF_VEC = 60'h04D_800_205_ED4_78F
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        in_valid,
  input  logic signed [XW-1:0]                        in_sample,
  output logic signed [XW+CW+clog2_min1(NTAPS)-1:0]   out_data
);

  localparam int AW   = XW + CW + clog2_min1(NTAPS);
  localparam int NDIG = CW + 1;

  function automatic longint tap_coef(int i);
    logic signed [CW-1:0] c;
    c = COEF_VEC[i*CW +: CW];
    return longint'(c);
  endfunction

  function automatic logic [NDIG-1:0] digit_mask(int sgn);
    logic [NDIG-1:0] m;
    m = '0;
    for (int i = 0; i < NTAPS; i++)
      for (int k = 0; k < NDIG; k++)
        if (csd_digit(tap_coef(i), k) == sgn) m[k] = 1'b1;
    return m;
  endfunction

  localparam logic [NDIG-1:0] USE_POS = digit_mask(1);
  localparam logic [NDIG-1:0] USE_NEG = digit_mask(-1);

  // Named internal events for the checker.
  logic signed [AW-1:0] pos_terms [NDIG];
  logic signed [AW-1:0] neg_terms [NDIG];
  logic signed [AW-1:0] tap_prod  [NTAPS];
  logic signed [AW-1:0] chain_head;

  fir_term_pool #(
    .XW(XW), .PW(AW), .NDIG(NDIG), .USE_POS(USE_POS), .USE_NEG(USE_NEG)
  ) u_pool (
    .x(in_sample), .pos_terms(pos_terms), .neg_terms(neg_terms)
  );

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    fir_const_mult #(
      .PW(AW), .NDIG(NDIG), .TAP_COEF(tap_coef(i))
    ) u_mult (
      .pos_terms(pos_terms), .neg_terms(neg_terms), .prod(tap_prod[i])
    );
  end

  fir_sum_chain #(.NTAPS(NTAPS), .PW(AW)) u_chain (
    .clk(clk), .rst(rst), .en(in_valid), .prods(tap_prod), .head(chain_head)
  );

  assign out_data = chain_head;

endmodule

// File: rtl/fir_csd_checker.sv
module fir_csd_checker #(
  parameter int NTAPS = 5,
  parameter int XW = 8,
  parameter int CW = 12,
  parameter int AW = 23,
  parameter logic [NTAPS*CW-1:0] COEF_VEC = '0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [XW-1:0] in_sample,
  input logic signed [AW-1:0] out_data,
  input logic signed [AW-1:0] tap_prod [NTAPS]
);

  function automatic longint cval(int i);
    logic signed [CW-1:0] c;
    c = COEF_VEC[i*CW +: CW];
    return longint'(c);
  endfunction

  function automatic longint mag_bound();
    longint s;
    s = 0;
    for (int i = 0; i < NTAPS; i++) s += (cval(i) < 0) ? -cval(i) : cval(i);
    return s * (longint'(1) << (XW - 1));
  endfunction

  localparam longint BOUND = mag_bound();

  // R1: a reset edge leaves the output at zero
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> out_data == '0);

  // R3: no valid sample, no movement
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R6: full precision never reaches wrap territory
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (longint'(out_data) <= BOUND) && (longint'(out_data) >= -BOUND));

  // R7: shift-and-add network matches a true product per tap
  for (genvar i = 0; i < NTAPS; i++) begin : g_prod
    a_r7_tap_product: assert property (@(posedge clk) disable iff (rst)
      longint'(tap_prod[i]) == longint'(in_sample) * cval(i));
  end

endmodule

bind fir_csd_transposed fir_csd_checker #(
  .NTAPS(NTAPS), .XW(XW), .CW(CW), .AW(AW), .COEF_VEC(COEF_VEC)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
  .out_data(out_data), .tap_prod(tap_prod)
);

// File: tb/fir_csd_transposed_test.sv
module fir_csd_transposed_test;

  localparam int NT = 5;
  localparam int XW = 8;
  localparam int OW = 23;
  localparam int C[NT] = '{1935, -300, 517, -2048, 77};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [XW-1:0] in_sample = '0;
  logic signed [OW-1:0] out_data;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int hist[$];

  always #10 clk = ~clk;

  fir_csd_transposed uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_sample(in_sample), .out_data(out_data)
  );

  function automatic longint model_out();
    longint s = 0;
    for (int k = 0; k < NT; k++) s += longint'(C[k]) * longint'(hist[k]);
    return s;
  endfunction

  task automatic check(string tag, longint exp);
    total++;
    if (longint'(out_data) != exp) begin
      bad++;
      $display("FAIL %s: out_data=%0d expected=%0d", tag, out_data, exp);
    end
  endtask

  // Drive on a falling edge, let one rising edge pass, compare on the next falling edge.
  task automatic tick(bit r, bit v, int x, string tag);
    rst = r;
    in_valid = v;
    in_sample = XW'(x);
    if (r) begin
      hist = {};
      for (int k = 0; k < NT; k++) hist.push_back(0);
    end else if (v) begin
      hist.push_front(x);
      void'(hist.pop_back());
    end
    @(negedge clk);
    check(tag, model_out());
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: out_data=%0d expected=finished", out_data);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NT; k++) hist.push_back(0);
    @(negedge clk);
    tick(1, 0, 0, "R1 reset");
    tick(1, 1, 55, "R1 reset ignores valid");
    tick(0, 1, 3, "R1 first sample sees zero history");

    // R4 impulse with idle gaps (R3)
    tick(1, 0, 0, "R1 reset");
    tick(0, 1, 1, "R4 impulse c0");
    tick(0, 0, 99, "R3 idle hold");
    tick(0, 0, -77, "R3 idle hold");
    for (int i = 1; i < NT + 2; i++) tick(0, 1, 0, "R4 impulse tail");

    // R5/R6 negative full scale impulse
    tick(0, 1, -128, "R5 negative impulse");
    for (int i = 1; i < NT + 1; i++) tick(0, 1, 0, "R5 negative tail");

    // R8 step
    for (int i = 0; i < NT + 3; i++) tick(0, 1, 127, "R8 step");
    check("R8 steady sum", longint'(127) * (1935 - 300 + 517 - 2048 + 77));

    // R6 extremes
    for (int i = 0; i < NT + 2; i++) tick(0, 1, -128, "R6 min run");
    for (int i = 0; i < 10; i++) tick(0, 1, (i % 2) ? 127 : -128, "R6 alternate");

    // R2 random data with random valid
    for (int i = 0; i < 300; i++)
      tick(0, ($urandom % 4) != 0, int'($urandom % 256) - 128, "R2 random");

    // R1 reset in mid-stream
    tick(1, 1, 42, "R1 mid reset");
    tick(0, 1, -9, "R1 post reset sample");
    tick(0, 0, 0, "R3 idle after reset");
    tick(0, 1, 4, "R2 continue");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule